// File: doc/BRIEF.md
# Sync-Pattern Word-Boundary Receiver

This block sits on the receive side of a multi-lane serial readout link. A capture front end has already sampled each lane in the middle of its bit cell. It hands over one receive slot at a time: a strobe plus one bit per lane. The link runs with 1, 2, 4 or 6 active lanes. The block merges the active lanes back into one ordered bit stream and recovers the 24-bit word framing without any handshake with the sender. It does this by hunting for a 14-bit sync pattern that no data word can contain.

Once framing is found and confirmed on the following word, the block decodes every hit word into its row, column, bunch-crossing and amplitude fields. Sync words are decoded into their 10 status bits. Every word must open with a mark bit of 1, and this is checked on each word as a running integrity test. A missing mark drops alignment, bumps a saturating loss counter and restarts the hunt. Output then resumes only after the next sync word has been found and confirmed.

Top module: `sync_frame_rx`

## Requirements
- R1: `lane_mode` picks the active lane count: 0 selects 1 lane, 1 selects 2, 2 selects 4 and 3 selects 6. In each strobed slot, lane 0 carries the earliest bit and the highest active lane carries the latest. Inactive lanes have no effect on any output.
- R2: Framing is set only by the sync pattern: a 1 followed by thirteen 0s, in transmit order. Before that pattern is seen, no hit or status output occurs and `aligned` stays 0.
- R3: The word following the first sync word is a verify word and is never output as a hit. `aligned` rises when the verify word completes with a good mark. Hits are output from the next word on.
- R4: A hit word in transmit order is: mark (1), row[6:0], col[4:0], bco[7:0], adc[2:0], each field MSB first. While aligned, each hit word pulses `hit_valid` for one cycle with these fields on the hit outputs.
- R5: A sync word is the mark, thirteen 0s, then status[9:0], MSB first. Each sync word completed after the pattern was found, including the first one, pulses `stat_valid` with `stat_bits`.
- R6: A word whose first bit is 0 after framing was found is a loss of alignment. `aligned` falls, the loss counter increments, and no hit or status output follows until a resync.
- R7: After a loss, the receiver realigns on the next sync word in the stream and resumes hit output after its verify word.
- R8: `col_err` pulses together with `hit_valid` when the two low bits of the hit's column are 00.
- R9: `lost_count` saturates at its all-ones value and is cleared only by `rst`.
- R10: A cycle with `slot_stb` low has no effect. A word's output pulses in the cycle after the edge that takes in the slot holding its last bit.
- R11: While `rst` (synchronous, active high) is held, `aligned`, `hit_valid`, `stat_valid`, `col_err` and `lost_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_mode | input | 2 | Active lane count select |
| slot_stb | input | 1 | Slot strobe: lane bits valid this cycle |
| lane_bits | input | 6 | One captured bit per lane |
| aligned | output | 1 | Framing confirmed, hit output enabled |
| hit_valid | output | 1 | One-cycle pulse per hit word |
| hit_row | output | 7 | Hit row address |
| hit_col | output | 5 | Hit column address |
| hit_bco | output | 8 | Hit bunch-crossing number |
| hit_adc | output | 3 | Hit pulse-height code |
| col_err | output | 1 | Hit column low bits were 00 |
| stat_valid | output | 1 | One-cycle pulse per sync word |
| stat_bits | output | 10 | Status field of the sync word |
| lost_count | output | 4 | Saturating alignment-loss count |

## Verification
The two functions that can land in one cycle are the completion of a word and a mark failure on the very next bit, when both sit inside one 6-lane slot. The bench provokes this by dropping a leading mark bit and later inserting a stray 0 bit. The drop shifts later word boundaries off slot edges, so the inserted 0 arrives mid-slot right after a word ends. The slot is judged correct when the finished word still appears in the output sequence, `lost_count` advances by exactly one, `aligned` falls in that same cycle, and nothing further comes out until the next sync and verify word.

// File: rtl/sync_frame_rx_pkg.sv
package sync_frame_rx_pkg;

    localparam int WORD_W    = 24;
    localparam int SYNC_W    = 14;
    localparam int STAT_W    = 10;
    localparam int MAX_LANES = 6;
    localparam int ROW_W     = 7;
    localparam int COL_W     = 5;
    localparam int BCO_W     = 8;
    localparam int ADC_W     = 3;
    localparam int CNT_W     = $clog2(WORD_W);
    localparam int NB_W      = $clog2(MAX_LANES + 1);

    localparam logic [SYNC_W-1:0] SYNC_PAT = {1'b1, {(SYNC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } frame_st_e;

    function automatic logic [NB_W-1:0] lanes_of(input logic [1:0] mode);
        case (mode)
            2'd0:    return NB_W'(1);
            2'd1:    return NB_W'(2);
            2'd2:    return NB_W'(4);
            default: return NB_W'(6);
        endcase
    endfunction

endpackage

// File: rtl/sfr_lane_merge.sv
module sfr_lane_merge
    import sync_frame_rx_pkg::*;
(
    input  logic [1:0]           mode,
    input  logic [MAX_LANES-1:0] lanes_in,
    output logic [NB_W-1:0]      nbits,
    output logic [MAX_LANES-1:0] bits_out
);

    always_comb begin
        nbits = lanes_of(mode);
    end

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_mask
        assign bits_out[g] = (NB_W'(g) < nbits) ? lanes_in[g] : 1'b0;
    end

endmodule

// File: rtl/sfr_frame_core.sv
module sfr_frame_core
    import sync_frame_rx_pkg::*;
#(
    parameter int LOST_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stb,
    input  logic [NB_W-1:0]      nbits,
    input  logic [MAX_LANES-1:0] bits_in,
    output logic                 locked,
    output logic                 hit_pulse,
    output logic                 stat_pulse,
    output logic [WORD_W-1:0]    word_out,
    output logic [LOST_W-1:0]    lost_cnt
);

    localparam int ZERO_HI = WORD_W - 2;
    localparam int ZERO_LO = WORD_W - SYNC_W;
    localparam logic [LOST_W-1:0] LOST_MAX = {LOST_W{1'b1}};

    typedef struct packed {
        frame_st_e          st;
        logic [CNT_W-1:0]   cnt;
        logic               vword;
        logic [SYNC_W-1:0]  hist;
        logic [WORD_W-1:0]  wbuf;
        logic [WORD_W-1:0]  word;
        logic               hit_vld;
        logic               stat_vld;
        logic [LOST_W-1:0]  lost;
    } core_t;

    core_t r_q, r_d;

    always_comb begin
        logic              b;
        logic [WORD_W-1:0] w;
        r_d          = r_q;
        r_d.hit_vld  = 1'b0;
        r_d.stat_vld = 1'b0;
        b            = 1'b0;
        w            = '0;
        if (stb) begin
            for (int i = 0; i < MAX_LANES; i++) begin
                if (NB_W'(i) < nbits) begin
                    b        = bits_in[i];
                    r_d.hist = {r_d.hist[SYNC_W-2:0], b};
                    if (r_d.st == ST_SEARCH) begin
                        if (r_d.hist == SYNC_PAT) begin
                            r_d.st    = ST_VERIFY;
                            r_d.vword = 1'b0;
                            r_d.cnt   = CNT_W'(SYNC_W);
                            r_d.wbuf  = WORD_W'(r_d.hist);
                        end
                    end else if (r_d.cnt == '0 && !b) begin
                        r_d.st  = ST_SEARCH;
                        r_d.cnt = '0;
                        if (r_d.lost != LOST_MAX) begin
                            r_d.lost = r_d.lost + 1'b1;
                        end
                    end else begin
                        w        = {r_d.wbuf[WORD_W-2:0], b};
                        r_d.wbuf = w;
                        if (r_d.cnt == CNT_W'(WORD_W - 1)) begin
                            r_d.cnt  = '0;
                            r_d.word = w;
                            if (w[ZERO_HI:ZERO_LO] == '0) begin
                                r_d.stat_vld = 1'b1;
                            end else if (r_d.st == ST_LOCKED) begin
                                r_d.hit_vld = 1'b1;
                            end
                            if (r_d.st == ST_VERIFY) begin
                                if (r_d.vword) begin
                                    r_d.st = ST_LOCKED;
                                end else begin
                                    r_d.vword = 1'b1;
                                end
                            end
                        end else begin
                            r_d.cnt = r_d.cnt + 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_SEARCH, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign locked     = (r_q.st == ST_LOCKED);
    assign hit_pulse  = r_q.hit_vld;
    assign stat_pulse = r_q.stat_vld;
    assign word_out   = r_q.word;
    assign lost_cnt   = r_q.lost;

endmodule

// File: rtl/sfr_word_fields.sv
module sfr_word_fields
    import sync_frame_rx_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic [BCO_W-1:0]  bco,
    output logic [ADC_W-1:0]  adc,
    output logic              col_bad,
    output logic [STAT_W-1:0] status
);

    localparam int ADC_LO = 0;
    localparam int BCO_LO = ADC_LO + ADC_W;
    localparam int COL_LO = BCO_LO + BCO_W;
    localparam int ROW_LO = COL_LO + COL_W;

    always_comb begin
        adc     = word[ADC_LO +: ADC_W];
        bco     = word[BCO_LO +: BCO_W];
        col     = word[COL_LO +: COL_W];
        row     = word[ROW_LO +: ROW_W];
        col_bad = (col[1:0] == 2'b00);
        status  = word[STAT_W-1:0];
    end

endmodule

// File: rtl/sync_frame_rx.sv
module sync_frame_rx
    import sync_frame_rx_pkg::*;
#(
    parameter int LOST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        lane_mode,
    input  logic              slot_stb,
    input  logic [5:0]        lane_bits,
    output logic              aligned,
    output logic              hit_valid,
    output logic [6:0]        hit_row,
    output logic [4:0]        hit_col,
    output logic [7:0]        hit_bco,
    output logic [2:0]        hit_adc,
    output logic              col_err,
    output logic              stat_valid,
    output logic [9:0]        stat_bits,
    output logic [LOST_W-1:0] lost_count
);

    logic [NB_W-1:0]      nbits;
    logic [MAX_LANES-1:0] merged;
    logic [WORD_W-1:0]    word;
    logic                 col_bad;

    sfr_lane_merge u_merge (
        .mode     (lane_mode),
        .lanes_in (lane_bits),
        .nbits    (nbits),
        .bits_out (merged)
    );

    sfr_frame_core #(.LOST_W(LOST_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .stb        (slot_stb),
        .nbits      (nbits),
        .bits_in    (merged),
        .locked     (aligned),
        .hit_pulse  (hit_valid),
        .stat_pulse (stat_valid),
        .word_out   (word),
        .lost_cnt   (lost_count)
    );

    sfr_word_fields u_fields (
        .word    (word),
        .row     (hit_row),
        .col     (hit_col),
        .bco     (hit_bco),
        .adc     (hit_adc),
        .col_bad (col_bad),
        .status  (stat_bits)
    );

    assign col_err = hit_valid & col_bad;

endmodule

// File: rtl/sync_frame_rx_chk.sv
module sync_frame_rx_chk #(
    parameter int LOST_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              slot_stb,
    input logic              aligned,
    input logic              hit_valid,
    input logic              col_err,
    input logic              stat_valid,
    input logic [LOST_W-1:0] lost_count
);

    localparam logic [LOST_W-1:0] LMAX = {LOST_W{1'b1}};

    // R3
    hit_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> $past(aligned));

    // R8
    col_err_qual_chk: assert property (@(posedge clk) disable iff (rst)
        col_err |-> hit_valid);

    // R5
    one_kind_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit_valid && stat_valid));

    // R9
    lost_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lost_count) == LMAX) |-> lost_count == LMAX);

    // R9
    lost_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lost_count == $past(lost_count) ||
                         lost_count == $past(lost_count) + 1'b1));

    // R6
    loss_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && lost_count != $past(lost_count)) |-> !aligned);

    // R10
    idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(slot_stb)) |-> (!hit_valid && !stat_valid));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(slot_stb)) |-> ($stable(aligned) && $stable(lost_count)));

endmodule

bind sync_frame_rx sync_frame_rx_chk #(.LOST_W(LOST_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slot_stb   (slot_stb),
    .aligned    (aligned),
    .hit_valid  (hit_valid),
    .col_err    (col_err),
    .stat_valid (stat_valid),
    .lost_count (lost_count)
);

// File: tb/sync_frame_rx_test.sv
module sync_frame_rx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] lane_mode = 2'd0;
    logic       slot_stb = 1'b0;
    logic [5:0] lane_bits = '0;
    logic       aligned, hit_valid, col_err, stat_valid;
    logic [6:0] hit_row;
    logic [4:0] hit_col;
    logic [7:0] hit_bco;
    logic [2:0] hit_adc;
    logic [9:0] stat_bits;
    logic [3:0] lost_count;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    bit          bq[$];
    logic [24:0] expq[$];
    logic [24:0] gotq[$];
    int          mphase;
    int          lost_exp;
    int          err_exp;
    int          err_got;
    bit          mon_en;

    always #4 clk = ~clk;

    sync_frame_rx uut (
        .clk(clk), .rst(rst), .lane_mode(lane_mode), .slot_stb(slot_stb),
        .lane_bits(lane_bits), .aligned(aligned), .hit_valid(hit_valid),
        .hit_row(hit_row), .hit_col(hit_col), .hit_bco(hit_bco), .hit_adc(hit_adc),
        .col_err(col_err), .stat_valid(stat_valid), .stat_bits(stat_bits),
        .lost_count(lost_count)
    );

    always @(posedge clk) begin
        #1;
        if (!rst && mon_en) begin
            if (hit_valid) gotq.push_back({2'b01, hit_row, hit_col, hit_bco, hit_adc});
            if (stat_valid) gotq.push_back({2'b10, 13'b0, stat_bits});
            if (hit_valid && col_err) err_got++;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int n_of(input logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 6;
    endfunction

    function automatic logic [23:0] mk_data(input logic [6:0] r, input logic [4:0] c,
                                            input logic [7:0] b, input logic [2:0] a);
        return {1'b1, r, c, b, a};
    endfunction

    function automatic logic [23:0] mk_sync(input logic [9:0] s);
        return {1'b1, 13'b0, s};
    endfunction

    task automatic push_word(input logic [23:0] w, input int from_bit);
        for (int i = from_bit; i >= 0; i--) bq.push_back(w[i]);
    endtask

    task automatic add_sync(input logic [9:0] s);
        push_word(mk_sync(s), 23);
        expq.push_back({2'b10, 13'b0, s});
        if (mphase == 0) mphase = 1;
        else if (mphase == 1) mphase = 2;
    endtask

    task automatic add_data(input logic [6:0] r, input logic [4:0] c,
                            input logic [7:0] b, input logic [2:0] a);
        push_word(mk_data(r, c, b, a), 23);
        if (mphase == 2) begin
            expq.push_back({2'b01, r, c, b, a});
            if (c[1:0] == 2'b00) err_exp++;
        end else if (mphase == 1) begin
            mphase = 2;
        end
    endtask

    function automatic logic [4:0] rand_col();
        logic [1:0] lo;
        lo = 2'($urandom_range(1, 3));
        return {3'($urandom), lo};
    endfunction

    task automatic add_data_rand();
        add_data(7'($urandom), rand_col(), 8'($urandom), 3'($urandom));
    endtask

    task automatic add_rand_word();
        if ($urandom % 5 == 0) add_sync(10'($urandom));
        else add_data_rand();
    endtask

    task automatic note_loss();
        if (mphase != 0 && lost_exp < 15) lost_exp++;
        mphase = 0;
    endtask

    // dropped leading mark bit; row MSB forced 0 so the slip is seen at once
    task automatic add_drop();
        push_word(mk_data({1'b0, 6'($urandom)}, rand_col(), 8'($urandom), 3'($urandom)), 22);
        note_loss();
    endtask

    // stray 0 bit slipped in ahead of a word
    task automatic add_insert();
        bq.push_back(1'b0);
        note_loss();
        push_word(mk_data(7'($urandom), rand_col(), 8'($urandom), 3'($urandom)), 23);
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1;
        slot_stb = 1'b0;
        lane_mode = m;
        mon_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(!aligned && !hit_valid && !stat_valid && !col_err, "R11 reset outputs",
            {aligned, hit_valid, stat_valid, col_err}, 0);
        chk(lost_count == 0, "R11/R9 reset count", lost_count, 0);
        rst = 1'b0;
        bq.delete(); expq.delete(); gotq.delete();
        mphase = 0; lost_exp = 0; err_exp = 0; err_got = 0;
        mon_en = 1'b1;
    endtask

    task automatic drive_stream(input int n);
        while (bq.size() > 0) begin
            @(negedge clk);
            if ($urandom % 4 == 0) begin
                slot_stb = 1'b0;
                lane_bits = 6'($urandom);
            end else begin
                slot_stb = 1'b1;
                for (int i = 0; i < 6; i++) begin
                    if (i < n) lane_bits[i] = bq.pop_front();
                    else lane_bits[i] = 1'($urandom);
                end
            end
        end
        @(negedge clk);
        slot_stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic judge(input string name);
        chk(gotq.size() == expq.size(), {"R1/R7 output count ", name}, gotq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < gotq.size(); i++) begin
            chk(gotq[i] == expq[i], (expq[i][24:23] == 2'b01) ? {"R4 hit word ", name} : {"R5 status word ", name},
                gotq[i], expq[i]);
        end
        chk(lost_count == 4'(lost_exp), {"R6/R9 loss count ", name}, lost_count, lost_exp);
        chk(err_got == err_exp, {"R8 col_err count ", name}, err_got, err_exp);
        chk(aligned == (mphase == 2), {"R7 aligned at end ", name}, aligned, mphase == 2);
    endtask

    task automatic run_phase(input logic [1:0] m, input int nwords, input int npairs, input string name);
        do_reset(m);
        repeat (3) add_data_rand();
        add_sync(10'($urandom));
        for (int p = 0; p < npairs; p++) begin
            repeat (nwords) add_rand_word();
            add_drop();
            add_data_rand();
            add_data_rand();
            add_sync(10'($urandom));
            repeat (nwords) add_rand_word();
            add_insert();
            add_data_rand();
            add_sync(10'($urandom));
        end
        repeat (nwords) add_rand_word();
        add_data(7'h41, 5'b10100, 8'h5A, 3'd6);
        add_data_rand();
        drive_stream(n_of(m));
        judge(name);
    endtask

    task automatic slot1(input bit b);
        @(negedge clk);
        slot_stb = 1'b1;
        lane_bits = {5'b10101, b};
        @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'h5EED_0C0D));
        mon_en = 1'b0;

        // directed: first sync then verify word, latency of a hit pulse, 1 lane
        do_reset(2'd0);
        chk(!aligned, "R2 not aligned before sync", aligned, 0);
        add_data_rand();
        add_data_rand();
        chk(1'b1, "R2 setup", 0, 0);
        drive_stream(1);
        chk(gotq.size() == 0 && !aligned, "R2 no output without sync", gotq.size(), 0);
        bq.delete(); expq.delete();
        add_sync(10'h2A5);
        add_data(7'h33, 5'b01101, 8'hC3, 3'd5);
        drive_stream(1);
        chk(gotq.size() == 1, "R3 verify word not output", gotq.size(), 1);
        if (gotq.size() > 0) chk(gotq[0] == {2'b10, 13'b0, 10'h2A5}, "R5 first status", gotq[0], 10'h2A5);
        chk(aligned == 1'b1, "R3 aligned after verify", aligned, 1);
        begin
            logic [23:0] w;
            int early;
            early = 0;
            w = mk_data(7'h12, 5'b11010, 8'h81, 3'd3);
            for (int i = 23; i >= 1; i--) begin
                slot1(w[i]);
                if (hit_valid || stat_valid) early++;
            end
            @(negedge clk);
            slot_stb = 1'b0;
            lane_bits = 6'h3F;
            @(posedge clk);
            #1;
            if (hit_valid) early++;
            chk(early == 0, "R10 no early pulse", early, 0);
            slot1(w[0]);
            chk(hit_valid && hit_row == 7'h12 && hit_col == 5'b11010 && hit_bco == 8'h81 && hit_adc == 3'd3,
                "R10/R4 hit pulse timing", {hit_valid, hit_row, hit_col, hit_bco, hit_adc},
                {1'b1, 7'h12, 5'b11010, 8'h81, 3'd3});
            @(negedge clk);
            slot_stb = 1'b0;
            @(posedge clk);
            #1;
            chk(!hit_valid, "R10 single-cycle pulse", hit_valid, 0);
        end

        run_phase(2'd0, 4, 1, "1-lane");
        run_phase(2'd1, 6, 2, "2-lane");
        run_phase(2'd2, 6, 2, "4-lane");
        run_phase(2'd3, 8, 3, "6-lane");
        run_phase(2'd3, 1, 9, "saturate");
        chk(lost_count == 4'hF, "R9 saturated count", lost_count, 15);
        do_reset(2'd3);
        chk(lost_count == 0, "R9 cleared by reset", lost_count, 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule